// File: doc/BRIEF.md
# Push-Button Greeting Line Transmitter

This block sends a fixed fourteen-character text line out of a single asynchronous serial output every time a push-button is seen pressed. The text is the twelve printable characters `Hello World!` followed by carriage return (13) and line feed (10). It is built into the block as a compile-time constant, so it never changes at run time. The button is asynchronous to the block clock and passes through a synchroniser first. Once a press is seen, the whole line is always sent. If the button is still held when the line finishes, the line starts again at once.

Each character is sent as one frame with 8 data bits, no parity and one stop bit, nominally at 115200 bit/s. Every bit lasts a whole number of microseconds: 9 µs, the 8.68 µs ideal rounded up. Each frame is preceded by a 17 µs stretch of idle-high line and followed by a 50 ms high gap, so a slow receiver has room to keep up. All durations are counted in clock cycles, derived from a clock-frequency parameter. A `busy` output shows when a line is in progress.

Top module: `msg_uart_sender`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `tx_o` is 1 and `busy_o` is 0.
- R2: While no line is being sent, `tx_o` stays 1 and `busy_o` stays 0, whatever time passes.
- R3: A high level on `btn_i` sampled at a rising clock edge makes `busy_o` rise exactly three rising edges later (two synchroniser flops, then the sequencer). A pulse on `btn_i` lasting a single cycle is enough.
- R4: Every character frame begins with `LEAD_US` µs (default 17) of `tx_o` = 1. The first such interval begins in the same cycle that `busy_o` rises.
- R5: The start bit that follows is `tx_o` = 0 for one bit time of `BIT_US` µs (default 9) = `CLK_HZ`/1e6 × `BIT_US` cycles.
- R6: Eight data bits follow, least-significant bit first, each held for exactly one bit time.
- R7: A stop bit of `tx_o` = 1, one bit time long, follows the data bits.
- R8: After the stop bit, `tx_o` is held at 1 for `GAP_US` µs (default 50000) with `busy_o` still 1. Only then does the next character's lead interval begin.
- R9: The characters go out in the order 72, 101, 108, 108, 111, 32, 87, 111, 114, 108, 100, 33, 13, 10.
- R10: If the synchronised button is low when the gap after the 14th character ends, `busy_o` falls in the very next cycle. `busy_o` is high for exactly 14 × (lead + 10 bit times + gap) cycles.
- R11: If the synchronised button is high when that last gap ends, the first character of a new line begins its lead interval at once. `busy_o` stays 1 with no break.
- R12: Once a line has begun, releasing the button has no effect until all 14 characters have been sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, frequency given by `CLK_HZ` |
| rst | input | 1 | Synchronous active-high reset |
| btn_i | input | 1 | Raw push-button level, high when pressed, asynchronous |
| tx_o | output | 1 | Registered serial data line, idle high |
| busy_o | output | 1 | High while a text line is being sent |

## Verification
A wrong character index or bit index shows up on `tx_o` within one bit time, as a wrong data level at a known sample. A wrong segment length, whether in the timer reload or in the lead, gap or bit count, moves every later edge on `tx_o`. That surfaces at the first sample past the faulty segment. A wrong decision at the end of a line shows on `busy_o` on the first cycle after the final gap: it either drops when the button is held or stays high when it is released.

// File: rtl/msu_pkg.sv
package msu_pkg;

   localparam int MSG_LEN = 14;
   localparam int CHR_W   = $clog2(MSG_LEN);

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LEAD,
      ST_START,
      ST_DATA,
      ST_STOP,
      ST_GAP
   } seg_e;

   function automatic logic [7:0] msg_byte(input logic [CHR_W-1:0] idx);
      logic [7:0] b;
      case (idx)
         4'd0:    b = 8'd72;
         4'd1:    b = 8'd101;
         4'd2:    b = 8'd108;
         4'd3:    b = 8'd108;
         4'd4:    b = 8'd111;
         4'd5:    b = 8'd32;
         4'd6:    b = 8'd87;
         4'd7:    b = 8'd111;
         4'd8:    b = 8'd114;
         4'd9:    b = 8'd108;
         4'd10:   b = 8'd100;
         4'd11:   b = 8'd33;
         4'd12:   b = 8'd13;
         default: b = 8'd10;
      endcase
      return b;
   endfunction

endpackage

// File: rtl/msu_sync.sv
module msu_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad
         $error("msu_sync needs at least two stages");
      end
      for (genvar k = 0; k < STAGES; k++) begin : g_stage
         always_ff @(posedge clk) begin
            if (rst) chain_q[k] <= 1'b0;
            else if (k == 0) chain_q[k] <= d_i;
            else chain_q[k] <= chain_q[(k == 0) ? 0 : k-1];
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/msu_timer.sv
module msu_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load_i,
   input  logic [W-1:0] val_i,
   output logic         done_o
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)                cnt_q <= '0;
      else if (load_i)        cnt_q <= val_i;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign done_o = (cnt_q == '0);
endmodule

// File: rtl/msg_uart_sender.sv
module msg_uart_sender #(
   parameter int CLK_HZ      = 50_000_000,
   parameter int BIT_US      = 9,
   parameter int LEAD_US     = 17,
   parameter int GAP_US      = 50_000,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic btn_i,
   output logic tx_o,
   output logic busy_o
);
   import msu_pkg::*;

   localparam int CYC_PER_US = CLK_HZ / 1_000_000;
   localparam int BIT_CYC    = CYC_PER_US * BIT_US;
   localparam int LEAD_CYC   = CYC_PER_US * LEAD_US;
   localparam int GAP_CYC    = CYC_PER_US * GAP_US;
   localparam int MAX_CYC    = (GAP_CYC > LEAD_CYC) ?
                               ((GAP_CYC > BIT_CYC) ? GAP_CYC : BIT_CYC) :
                               ((LEAD_CYC > BIT_CYC) ? LEAD_CYC : BIT_CYC);
   localparam int CW         = $clog2(MAX_CYC + 1);
   localparam logic [CHR_W-1:0] LAST_CHR = CHR_W'(MSG_LEN - 1);

   generate
      if (CLK_HZ % 1_000_000 != 0 || CLK_HZ < 1_000_000) begin : g_bad_clk
         $error("CLK_HZ must be a whole number of MHz");
      end
      if (BIT_US < 1 || LEAD_US < 1 || GAP_US < 1) begin : g_bad_time
         $error("all interval lengths must be at least 1 us");
      end
   endgenerate

   logic          btn_s;
   logic          seg_end;
   logic          load;
   logic [CW-1:0] load_val;

   seg_e             st_q, st_n;
   logic [CHR_W-1:0] chr_q, chr_n;
   logic [2:0]       bit_q, bit_n;
   logic             tx_q, tx_n;
   logic [7:0]       byte_n;

   msu_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .d_i(btn_i), .q_o(btn_s)
   );

   msu_timer #(.W(CW)) u_tmr (
      .clk(clk), .rst(rst), .load_i(load), .val_i(load_val), .done_o(seg_end)
   );

   always_comb begin
      st_n     = st_q;
      chr_n    = chr_q;
      bit_n    = bit_q;
      load     = 1'b0;
      load_val = CW'(BIT_CYC - 1);
      case (st_q)
         ST_IDLE: if (btn_s) begin
            st_n     = ST_LEAD;
            chr_n    = '0;
            load     = 1'b1;
            load_val = CW'(LEAD_CYC - 1);
         end
         ST_LEAD: if (seg_end) begin
            st_n = ST_START;
            load = 1'b1;
         end
         ST_START: if (seg_end) begin
            st_n  = ST_DATA;
            bit_n = '0;
            load  = 1'b1;
         end
         ST_DATA: if (seg_end) begin
            load = 1'b1;
            if (bit_q == 3'd7) st_n = ST_STOP;
            else bit_n = bit_q + 3'd1;
         end
         ST_STOP: if (seg_end) begin
            st_n     = ST_GAP;
            load     = 1'b1;
            load_val = CW'(GAP_CYC - 1);
         end
         ST_GAP: if (seg_end) begin
            if (chr_q != LAST_CHR) begin
               st_n     = ST_LEAD;
               chr_n    = chr_q + 1'b1;
               load     = 1'b1;
               load_val = CW'(LEAD_CYC - 1);
            end else if (btn_s) begin
               st_n     = ST_LEAD;
               chr_n    = '0;
               load     = 1'b1;
               load_val = CW'(LEAD_CYC - 1);
            end else begin
               st_n = ST_IDLE;
            end
         end
         default: st_n = ST_IDLE;
      endcase
   end

   always_comb begin
      byte_n = msg_byte(chr_n);
      case (st_n)
         ST_START: tx_n = 1'b0;
         ST_DATA:  tx_n = byte_n[bit_n];
         default:  tx_n = 1'b1;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q  <= ST_IDLE;
         chr_q <= '0;
         bit_q <= '0;
         tx_q  <= 1'b1;
      end else begin
         st_q  <= st_n;
         chr_q <= chr_n;
         bit_q <= bit_n;
         tx_q  <= tx_n;
      end
   end

   assign tx_o   = tx_q;
   assign busy_o = (st_q != ST_IDLE);
endmodule

// File: rtl/msu_checker.sv
module msu_checker #(
   parameter int CHR_W = 4,
   parameter int LAST  = 13
) (
   input logic             clk,
   input logic             rst,
   input logic             btn_s,
   input logic             seg_end,
   input logic [CHR_W-1:0] chr,
   input logic             tx,
   input logic             busy
);
   assert_reset_R1: assert property (@(posedge clk) rst |=> (tx && !busy));

   assert_idle_high_R2: assert property (@(posedge clk) disable iff (rst)
      !busy |-> tx);

   assert_start_cause_R3: assert property (@(posedge clk) disable iff (rst)
      $rose(busy) |-> $past(btn_s));

   assert_low_only_busy_R5: assert property (@(posedge clk) disable iff (rst)
      $fell(tx) |-> busy);

   assert_edge_on_boundary_R6: assert property (@(posedge clk) disable iff (rst)
      !$stable(tx) |-> $past(seg_end));

   assert_end_after_last_R10: assert property (@(posedge clk) disable iff (rst)
      $fell(busy) |-> ($past(chr) == CHR_W'(LAST) && $past(seg_end) && !$past(btn_s)));
endmodule

bind msg_uart_sender msu_checker #(.CHR_W(msu_pkg::CHR_W), .LAST(msu_pkg::MSG_LEN - 1)) u_chk (
   .clk(clk), .rst(rst), .btn_s(btn_s), .seg_end(seg_end),
   .chr(chr_q), .tx(tx_o), .busy(busy_o)
);

// File: tb/sim_msg_uart_sender.sv
`timescale 1ns/1ps
module sim_msg_uart_sender;
   localparam int CLK_HZ = 2_000_000;
   localparam int CPU    = CLK_HZ / 1_000_000;
   localparam int L      = CPU * 17;
   localparam int B      = CPU * 9;
   localparam int G      = CPU * 20;
   localparam int PER    = L + 10*B + G;
   localparam int M      = 14 * PER;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic btn = 1'b0;
   logic tx, busy;
   int   n_chk = 0;
   int   n_bad = 0;
   bit   done  = 1'b0;

   always #2 clk = ~clk;

   msg_uart_sender #(.CLK_HZ(CLK_HZ), .BIT_US(9), .LEAD_US(17), .GAP_US(20)) u0 (
      .clk(clk), .rst(rst), .btn_i(btn), .tx_o(tx), .busy_o(busy)
   );

   function automatic logic [7:0] exp_char(int c);
      string g = "Hello World!";
      if (c < 12) return g.getc(c);
      return (c == 12) ? 8'd13 : 8'd10;
   endfunction

   function automatic logic exp_tx(int s, output string tag);
      int c = (s % M) / PER;
      int r = s % PER;
      if (r < L) begin tag = "R4"; return 1'b1; end
      r -= L;
      if (r < B) begin tag = "R5"; return 1'b0; end
      r -= B;
      if (r < 8*B) begin tag = "R6/R9"; return exp_char(c)[r / B]; end
      r -= 8*B;
      if (r < B) begin tag = "R7"; return 1'b1; end
      tag = "R8";
      return 1'b1;
   endfunction

   task automatic check(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   // press for hold cycles, then check n_msg lines sent back to back
   task automatic send(input int hold, input int n_msg);
      string tag;
      btn = 1'b1;
      fork
         begin repeat (hold) @(negedge clk); btn = 1'b0; end
      join_none
      repeat (2) @(negedge clk);
      check("R3 busy not yet", busy, 1'b0);
      @(negedge clk);
      check("R3 busy rise", busy, 1'b1);
      for (int s = 0; s < n_msg * M; s++) begin
         if (s > 0) @(negedge clk);
         check(tag, tx, exp_tx(s, tag));
         check((n_msg > 1 && s >= M) ? "R11 busy" : "R8/R12 busy", busy, 1'b1);
      end
      @(negedge clk);
      check("R10 busy fall", busy, 1'b0);
      check("R10 tx idle", tx, 1'b1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      int seed = 17;
      void'($urandom(seed));
      repeat (4) @(negedge clk);
      check("R1 tx in reset", tx, 1'b1);
      check("R1 busy in reset", busy, 1'b0);
      rst = 1'b0;
      @(negedge clk);
      check("R1 tx after reset", tx, 1'b1);
      check("R1 busy after reset", busy, 1'b0);
      repeat (20 + $urandom_range(40)) @(negedge clk);
      check("R2 tx idle", tx, 1'b1);
      check("R2 busy idle", busy, 1'b0);
      // single-cycle press: R3 and R12
      send(1, 1);
      repeat (10) @(negedge clk);
      check("R2 tx idle after line", tx, 1'b1);
      // held through the first line: R11
      send(M + 200, 2);
      // random press lengths within one line: R12
      for (int k = 0; k < 3; k++) begin
         repeat (1 + $urandom_range(30)) @(negedge clk);
         send(1 + $urandom_range(M - 50), 1);
      end
      // release just before the last gap ends: R10
      send(M - 10, 1);
      summary();
   end
endmodule